// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the register file and control logic that sits between a simple 32-bit word bus and the serial engine of a four-channel SPI master. Software writes words into a transmit queue and reads words out of a receive queue through two data registers. A control register selects the active channel, the mode of each channel and how transfers are started. A status register reports the queue levels and two sticky events, and an interrupt-enable register masks the status into one level-sensitive interrupt line.

The serial shifting happens in a separate burst engine. This block gives that engine a one-cycle start pulse, and the engine answers with a done pulse. The engine pops transmit words and pushes received words through the two queue ports. The block also drives the active-low chip selects. Clearing the enable bit performs a soft reset that keeps the written control value and returns everything else to its idle state.

Register indices (byte address bits [7:2]): 0 receive data, 1 transmit data, 2 control, 3 config, 4 interrupt enable, 5 status. Control fields: bit 0 enable, bit 1 exchange request, bit 2 start-on-write mode, bits [7:4] per-channel master flags, bits [13:12] selected channel. Status bits: 0 transmit queue empty, 1 transmit queue has room, 2 receive data ready, 3 transmit queue full, 4 receive queue full, 5 receive overflow, 6 transfer complete.

Top module: `spi_regfront`

## Requirements
- R1: Register index is bus_addr[7:2]. Indices 0 to 5 map to receive data, transmit data, control, config, interrupt enable and status. Config and interrupt enable read back what was written. Any index of 6 or more reads as 0, and writes to such an index have no effect. Read data appears on bus_rdata one cycle after bus_rd.
- R2: While control bit 0 (enable) is 0, writes to every register except control are ignored.
- R3: A control write with bit 0 clear is a soft reset. Control takes the written value. Config and interrupt enable become 0. Both queues are emptied. Overflow and complete are cleared. Status reads 0x00000003. All chip selects go high.
- R4: Status bits 0 to 4 follow the queue levels and are updated one cycle after a push or pop. An empty transmit queue with an empty receive queue reads as 0x03.
- R5: Writing status clears bit 5 (overflow) and bit 6 (complete) wherever the written word has a 1. All other written bits have no effect.
- R6: irq is high exactly when (status AND interrupt enable) is nonzero.
- R7: A transmit-data write to a full queue (64 words) discards the word. Otherwise the word is queued in order. If the selected channel is master and control bit 2 is 1, xfer_start pulses.
- R8: A control write with enable 1 and a master channel selected drives that channel's cs_n low and the others high. At most one cs_n is low at any time.
- R9: On such a control write, xfer_start pulses if bit 2 goes 0 to 1 with a non-empty transmit queue, or otherwise if bit 1 goes 0 to 1 while the new bit 2 is 0.
- R10: Reading receive data while enabled pops the receive queue, or returns 0xDEADBEEF if the queue is empty. Reading transmit data returns 0. Reading receive data while disabled returns 0 and pops nothing.
- R11: The selected channel is master when bit (4 + channel select) of control is 1.
- R12: Hard reset sets control to 0 and drives all cs_n high.
- R13: xfer_done sets complete (bit 6). It also clears control bit 1 if the transmit queue is empty. A receive push into a full queue is dropped and sets overflow (bit 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| cs_n | output | 4 | Active-low chip selects |
| xfer_start | output | 1 | One-cycle start pulse to the burst engine |
| xfer_done | input | 1 | Burst engine completion pulse |
| tx_pop | input | 1 | Engine takes the head transmit word |
| tx_word | output | 32 | Head of the transmit queue |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | 32 | Received word |

## Verification
If a queue pointer or count goes wrong, the fault shows at the ports within one cycle. The status word misreports empty or full, and irq follows it. Data then leaves through tx_word or bus_rdata out of order, or a word is duplicated or dropped. If the start logic is wrong, xfer_start pulses on the wrong edge of the control bits, or after a write that should have been discarded. A sweep over every channel select and mode pattern exposes these on the next register write. A bad soft reset leaves a chip select low or a stale status bit set, and this is visible at the first read after the disabling write.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  localparam int REG_RX   = 0;
  localparam int REG_TX   = 1;
  localparam int REG_CTRL = 2;
  localparam int REG_CFG  = 3;
  localparam int REG_IEN  = 4;
  localparam int REG_STAT = 5;

  localparam int CB_EN   = 0;
  localparam int CB_XCH  = 1;
  localparam int CB_SMC  = 2;
  localparam int CB_MODE = 4;
  localparam int CB_SEL  = 12;

  localparam int ST_TXE   = 0;
  localparam int ST_TXRM  = 1;
  localparam int ST_RXRDY = 2;
  localparam int ST_TXF   = 3;
  localparam int ST_RXF   = 4;
  localparam int ST_OVF   = 5;
  localparam int ST_TC    = 6;

  localparam logic [31:0] RX_EMPTY_WORD = 32'hDEADBEEF;

  // Channel select field of a control word.
  function automatic int chan_sel(input logic [31:0] c, input int selw);
    return int'((c >> CB_SEL) & ((32'd1 << selw) - 32'd1));
  endfunction

  // Master flag of the selected channel.
  function automatic logic chan_is_master(input logic [31:0] c, input int selw);
    return c[CB_MODE + chan_sel(c, selw)];
  endfunction

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(count));

  assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/spi_rf_status.sv
module spi_rf_status
  import spi_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        tx_empty,
  input  logic        tx_full,
  input  logic        rx_empty,
  input  logic        rx_full,
  input  logic        ovf_set,
  input  logic        tc_set,
  input  logic        clr_ovf,
  input  logic        clr_tc,
  input  logic [31:0] ien,
  output logic [31:0] status,
  output logic        irq
);
  logic ovf_q, tc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      tc_q  <= 1'b0;
    end else if (flush) begin
      ovf_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      ovf_q <= (ovf_q & ~clr_ovf) | ovf_set;
      tc_q  <= (tc_q & ~clr_tc) | tc_set;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_TXE]   = tx_empty;
    status[ST_TXRM]  = ~tx_full;
    status[ST_RXRDY] = ~rx_empty;
    status[ST_TXF]   = tx_full;
    status[ST_RXF]   = rx_full;
    status[ST_OVF]   = ovf_q;
    status[ST_TC]    = tc_q;
  end

  assign irq = |(status & ien);

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !ovf_set) |=> !status[ST_OVF]);

  assert_done_sets_tc_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set && !flush) |=> status[ST_TC]);

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CS     = 4,
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [NUM_CS-1:0] cs_n,
  output logic              xfer_start,
  input  logic              xfer_done,
  input  logic              tx_pop,
  output logic [31:0]       tx_word,
  input  logic              rx_push,
  input  logic [31:0]       rx_word
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [IDX_W-1:0] I_RX   = IDX_W'(REG_RX);
  localparam logic [IDX_W-1:0] I_TX   = IDX_W'(REG_TX);
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(REG_CTRL);
  localparam logic [IDX_W-1:0] I_CFG  = IDX_W'(REG_CFG);
  localparam logic [IDX_W-1:0] I_IEN  = IDX_W'(REG_IEN);
  localparam logic [IDX_W-1:0] I_STAT = IDX_W'(REG_STAT);

  logic [IDX_W-1:0]  idx;
  logic              unused_addr_lsb;
  logic [31:0]       ctrl_q, cfg_q, ien_q, rdata_q, status_w, rd_val, rx_head;
  logic [NUM_CS-1:0] cs_q;
  logic              start_q, en_q;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  // named internal events
  logic ev_ctrl_wr, ev_soft_rst, ev_ctrl_on, ev_new_master;
  logic ev_tx_wr, ev_rx_pop, ev_start_ctrl, ev_start_tx, ev_xch_clr;
  logic ev_cfg_wr, ev_ien_wr, ev_stat_wr, ev_rx_ovf;

  assign idx             = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign en_q            = ctrl_q[CB_EN];

  assign ev_ctrl_wr    = bus_wr && idx == I_CTRL;
  assign ev_soft_rst   = ev_ctrl_wr && !bus_wdata[CB_EN];
  assign ev_ctrl_on    = ev_ctrl_wr && bus_wdata[CB_EN];
  assign ev_new_master = chan_is_master(bus_wdata, SEL_W);
  assign ev_tx_wr      = bus_wr && en_q && idx == I_TX;
  assign ev_cfg_wr     = bus_wr && en_q && idx == I_CFG;
  assign ev_ien_wr     = bus_wr && en_q && idx == I_IEN;
  assign ev_stat_wr    = bus_wr && en_q && idx == I_STAT;
  assign ev_rx_pop     = bus_rd && en_q && idx == I_RX && !rx_empty;
  assign ev_rx_ovf     = rx_push && rx_full;
  assign ev_xch_clr    = xfer_done && tx_empty;

  assign ev_start_ctrl = ev_ctrl_on && ev_new_master &&
    ((bus_wdata[CB_SMC] && !ctrl_q[CB_SMC] && !tx_empty) ||
     (bus_wdata[CB_XCH] && !ctrl_q[CB_XCH] && !bus_wdata[CB_SMC]));
  assign ev_start_tx   = ev_tx_wr && !tx_full &&
    chan_is_master(ctrl_q, SEL_W) && ctrl_q[CB_SMC];

  spi_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(ev_soft_rst),
    .push(ev_tx_wr), .wdata(bus_wdata), .pop(tx_pop), .rdata(tx_word),
    .empty(tx_empty), .full(tx_full));

  spi_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(ev_soft_rst),
    .push(rx_push), .wdata(rx_word), .pop(ev_rx_pop), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full));

  spi_rf_status u_stat (
    .clk(clk), .rst_n(rst_n), .flush(ev_soft_rst),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
    .ovf_set(ev_rx_ovf), .tc_set(xfer_done),
    .clr_ovf(ev_stat_wr && bus_wdata[ST_OVF]), .clr_tc(ev_stat_wr && bus_wdata[ST_TC]),
    .ien(ien_q), .status(status_w), .irq(irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cfg_q   <= '0;
      ien_q   <= '0;
      cs_q    <= '1;
      start_q <= 1'b0;
    end else begin
      start_q <= ev_start_ctrl || ev_start_tx;
      if (ev_ctrl_wr) begin
        ctrl_q <= bus_wdata;
      end else if (ev_xch_clr) begin
        ctrl_q[CB_XCH] <= 1'b0;
      end
      if (ev_soft_rst) begin
        cfg_q <= '0;
        ien_q <= '0;
        cs_q  <= '1;
      end else begin
        if (ev_cfg_wr) cfg_q <= bus_wdata;
        if (ev_ien_wr) ien_q <= bus_wdata;
        if (ev_ctrl_on && ev_new_master)
          cs_q <= ~(NUM_CS'(1) << chan_sel(bus_wdata, SEL_W));
      end
    end
  end

  always_comb begin
    case (idx)
      I_RX:    rd_val = !en_q ? 32'd0 : (rx_empty ? RX_EMPTY_WORD : rx_head);
      I_CTRL:  rd_val = ctrl_q;
      I_CFG:   rd_val = cfg_q;
      I_IEN:   rd_val = ien_q;
      I_STAT:  rd_val = status_w;
      default: rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata  = rdata_q;
  assign cs_n       = cs_q;
  assign xfer_start = start_q;

  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_start_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> ctrl_q[CB_EN]);

  assert_disabled_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !en_q && idx == I_IEN) |=> $stable(ien_q));

  assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft_rst |=> (cs_n == '1 && status_w == 32'h3 && !xfer_start));

endmodule

// File: tb/sim_spi_regfront.sv
`timescale 1ns/1ps
module sim_spi_regfront;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, tx_word, rx_word = 0;
  logic        irq, xfer_start, xfer_done = 0, tx_pop = 0, rx_push = 0;
  logic [3:0]  cs_n;
  int          n_run = 0, n_fail = 0, starts = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  spi_regfront u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .cs_n(cs_n), .xfer_start(xfer_start), .xfer_done(xfer_done), .tx_pop(tx_pop),
    .tx_word(tx_word), .rx_push(rx_push), .rx_word(rx_word));

  always @(negedge clk) if (xfer_start) starts++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = 8'(idx * 4); bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_wr = 0; #1;
  endtask

  task automatic rd(int idx, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = 8'(idx * 4);
    @(posedge clk); @(negedge clk); bus_rd = 0; #1; d = bus_rdata;
  endtask

  task automatic eng_pop(output logic [31:0] w);
    @(negedge clk); tx_pop = 1; w = tx_word;
    @(posedge clk); @(negedge clk); tx_pop = 0; #1;
  endtask

  task automatic eng_push(logic [31:0] w);
    @(negedge clk); rx_push = 1; rx_word = w;
    @(posedge clk); @(negedge clk); rx_push = 0; #1;
  endtask

  task automatic done_pulse();
    @(negedge clk); xfer_done = 1;
    @(posedge clk); @(negedge clk); xfer_done = 0; #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  localparam logic [31:0] EN = 32'h1, XCH = 32'h2, SMC = 32'h4;
  localparam logic [31:0] M  = EN | 32'h10;   // channel 0 master, selected

  initial begin
    logic [31:0] v, w;
    logic [3:0]  exp_cs;
    int          s0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R12 / R4 reset state
    check("R12 cs_n", 32'(cs_n), 32'hF);
    check("R6 irq", 32'(irq), 0);
    rd(2, v); check("R12 ctrl", v, 0);
    rd(5, v); check("R4 status", v, 32'h3);
    // R2 disabled writes ignored
    wr(4, 32'hFF); rd(4, v); check("R2 ien", v, 0);
    wr(1, 32'h1);
    wr(2, EN); rd(5, v); check("R2 tx ignored", v, 32'h3);
    check("R11 slave cs", 32'(cs_n), 32'hF);
    // R1 map and out-of-range
    wr(3, 32'hA5A50F0F); rd(3, v); check("R1 cfg", v, 32'hA5A50F0F);
    wr(9, 32'hFFFF); rd(9, v); check("R1 idx9", v, 0);
    rd(6, v); check("R1 idx6", v, 0);
    rd(3, v); check("R1 cfg kept", v, 32'hA5A50F0F);
    // R8 R9 R11 sweep over select and mode
    exp_cs = 4'hF;
    for (int sel = 0; sel < 4; sel++) begin
      for (int mode = 0; mode < 16; mode++) begin
        logic [31:0] base;
        bit          mst;
        base = EN | 32'(mode << 4) | 32'(sel << 12);
        mst  = ((mode >> sel) & 1) == 1;
        s0 = starts;
        wr(2, base);
        if (mst) exp_cs = ~(4'd1 << sel);
        check("R8 cs", 32'(cs_n), 32'(exp_cs));
        check("R9 no start xch0", 32'(starts - s0), 0);
        wr(2, base | XCH);
        check("R11 xch start", 32'(starts - s0), mst ? 1 : 0);
      end
    end
    // R7 fill, drop, order
    wr(2, M); check("R8 ch0", 32'(cs_n), 32'hE);
    for (int i = 0; i < 64; i++) wr(1, 32'h10000000 + 32'(i));
    rd(5, v); check("R4 tx full", v, 32'h08);
    wr(1, 32'hBAD00000);
    for (int i = 0; i < 64; i++) begin
      eng_pop(w); check("R7 order", w, 32'h10000000 + 32'(i));
    end
    rd(5, v); check("R7 drop", v, 32'h03);
    // R9 / R7 start modes
    s0 = starts; wr(2, M | SMC); check("R9 smc empty", 32'(starts - s0), 0);
    s0 = starts; wr(1, 32'h55);  check("R7 smc tx start", 32'(starts - s0), 1);
    s0 = starts; wr(2, M);       check("R9 smc off", 32'(starts - s0), 0);
    s0 = starts; wr(2, M | SMC); check("R9 smc rise", 32'(starts - s0), 1);
    s0 = starts; wr(2, M | XCH); check("R9 xch rise", 32'(starts - s0), 1);
    // R13 done handling
    done_pulse();
    rd(2, v); check("R13 xch kept", v, M | XCH);
    rd(5, v); check("R13 tc", v, 32'h42);
    eng_pop(w); check("R7 word", w, 32'h55);
    done_pulse();
    rd(2, v); check("R13 xch clr", v, M);
    rd(5, v); check("R13 tc empty", v, 32'h43);
    // R10 receive path
    eng_push(32'hAAAA0001); eng_push(32'hBBBB0002);
    rd(5, v); check("R4 rx ready", v, 32'h47);
    rd(0, v); check("R10 rx a", v, 32'hAAAA0001);
    rd(0, v); check("R10 rx b", v, 32'hBBBB0002);
    rd(0, v); check("R10 empty", v, 32'hDEADBEEF);
    rd(1, v); check("R10 tx read", v, 0);
    rd(5, v); check("R4 rx drained", v, 32'h43);
    // R13 overflow, R6 irq, R5 w1c
    for (int i = 0; i < 65; i++) eng_push(32'(i));
    rd(5, v); check("R13 ovf", v, 32'h77);
    wr(4, 32'h20); check("R6 irq on", 32'(irq), 1);
    wr(5, 32'hFFFFFFFF); rd(5, v); check("R5 w1c", v, 32'h17);
    check("R6 irq off", 32'(irq), 0);
    // R3 soft reset
    wr(4, 32'h04); check("R6 irq rx", 32'(irq), 1);
    wr(2, 32'h00001230);
    check("R3 cs", 32'(cs_n), 32'hF);
    check("R3 irq", 32'(irq), 0);
    rd(2, v); check("R3 ctrl kept", v, 32'h00001230);
    rd(5, v); check("R3 status", v, 32'h3);
    rd(4, v); check("R3 ien", v, 0);
    rd(3, v); check("R3 cfg", v, 0);
    rd(0, v); check("R10 disabled rx", v, 0);
    wr(2, M); rd(0, v); check("R3 rx flushed", v, 32'hDEADBEEF);
    check("R8 re-enable", 32'(cs_n), 32'hE);
    finished = 1;
    summary();
  end
endmodule